// File: doc/BRIEF.md
# UART status flag and idle-line block

This block keeps the four status flags of a UART-style serial port and folds them into a single interrupt request. The transmit side reports two things. The transmit-empty flag says the data register is free again. The transmission-complete flag says that nothing at all is left to send. The transmit datapath supplies strobes and levels for these: a pulse when the data register hands its character to the shifter, a level for an empty shifter, and a level for a queued break or idle character.

The receive side has a receive-full flag, raised by the strobe that moves a character into the receive data register. It also has an idle-line flag. That flag comes from counting consecutive ones on the receive line, sampled only on a bit-rate strobe. The count needed is 10 or 11, chosen by a frame-length input.

Software clears transmit-empty and transmission-complete by writing the data register. It clears receive-full and idle with a status read followed later by a data read. Each flag has its own enable. The interrupt request is registered.

Top module: `uart_stat_flags`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the outputs are flag_txe=1, flag_tc=1, flag_rxf=0, flag_idle=0 and irq=0.
- R2: A tx_load pulse sets flag_txe at that clock edge. A dr_write pulse clears it at that edge. When both arrive in the same cycle, the write wins.
- R3: flag_tc sets one edge after a cycle in which flag_txe=1, tx_shift_empty=1 and brk_idle_pending=0 all hold. It stays clear while the shifter is busy or a break/idle is queued. dr_write clears it.
- R4: An rx_xfer pulse sets flag_rxf at that edge.
- R5: A stat_read pulse records which of flag_rxf and flag_idle are set. A later dr_read clears exactly the recorded flags. A dr_read with no stat_read before it changes nothing. A set arriving in the same cycle as the clear wins.
- R6: On cycles with bit_tick=1, consecutive rx_line=1 samples are counted. flag_idle sets at the edge of the 10th such sample when long_frame=0, and of the 11th when long_frame=1.
- R7: A bit_tick sample with rx_line=0 restarts the count from zero. The value of rx_line on cycles without bit_tick has no effect.
- R8: flag_idle sets only once per run of ones. After it has set and been cleared, further ones do not set it again until a zero has been sampled.
- R9: irq equals, one cycle later, the OR of (flag_txe & en_txe), (flag_tc & en_tc), (flag_rxf & en_rxf) and (flag_idle & en_idle). Each enable affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_load | input | 1 | Pulse: data register moved into the transmit shifter |
| tx_shift_empty | input | 1 | Level: transmit shifter holds no character |
| brk_idle_pending | input | 1 | Level: break or idle character queued |
| dr_write | input | 1 | Pulse: transmit data register written |
| rx_xfer | input | 1 | Pulse: receive shifter moved into the data register |
| bit_tick | input | 1 | Bit-rate sample strobe |
| rx_line | input | 1 | Receive line level |
| long_frame | input | 1 | 0: idle after 10 ones, 1: idle after 11 ones |
| stat_read | input | 1 | Pulse: status read |
| dr_read | input | 1 | Pulse: receive data register read |
| en_txe | input | 1 | Enable for transmit-empty request |
| en_tc | input | 1 | Enable for transmission-complete request |
| en_rxf | input | 1 | Enable for receive-full request |
| en_idle | input | 1 | Enable for idle-line request |
| flag_txe | output | 1 | Transmit data register empty |
| flag_tc | output | 1 | Transmission complete |
| flag_rxf | output | 1 | Receive data register full |
| flag_idle | output | 1 | Idle line detected |
| irq | output | 1 | Registered interrupt request |

## Verification
Flags driven by a strobe (transmit-empty, receive-full, idle, and the clears) change at the same edge that samples the strobe. Transmission-complete changes one edge after its three conditions hold. The request follows a flag or enable change by one more edge. The driver therefore pushes each expected value into the scoreboard just after the edge that should produce it, and includes the deliberate one-cycle lag of the request in cases where a flag has just changed. The monitor compares these values on the falling edge, well away from the edges where the inputs change. Idle strobes are spaced with a gap cycle that drives the line low, so the same runs also test that samples taken without a strobe are ignored.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
   typedef struct packed {
      logic txe;
      logic tc;
      logic rxf;
      logic idle;
   } stat_t;
endpackage

// File: rtl/uart_idle_detect.sv
module uart_idle_detect #(
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic rx_line,
   input  logic long_frame,
   output logic idle_hit
);
   localparam int CW = $clog2(IDLE_LONG + 1);

   logic [CW-1:0] run_cnt;
   logic [CW-1:0] thr;
   logic          armed;

   generate
      if (IDLE_SHORT < 2) begin : g_bad_short
         $error("uart_idle_detect: IDLE_SHORT must be at least 2");
      end
      if (IDLE_LONG < IDLE_SHORT) begin : g_bad_long
         $error("uart_idle_detect: IDLE_LONG must not be below IDLE_SHORT");
      end
      if (IDLE_SHORT == IDLE_LONG) begin : g_fixed_thr
         logic unused_sel;
         assign unused_sel = long_frame;
         assign thr = CW'(IDLE_SHORT);
      end else begin : g_sel_thr
         assign thr = long_frame ? CW'(IDLE_LONG) : CW'(IDLE_SHORT);
      end
   endgenerate

   assign idle_hit = bit_tick & rx_line & armed & (run_cnt == thr - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         armed   <= 1'b1;
      end else if (bit_tick) begin
         if (!rx_line) begin
            run_cnt <= '0;
            armed   <= 1'b1;
         end else if (idle_hit) begin
            run_cnt <= '0;
            armed   <= 1'b0;
         end else if (armed) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_load,
   input  logic dr_write,
   input  logic tx_shift_empty,
   input  logic brk_idle_pending,
   output logic txe,
   output logic tc
);
   logic drained;

   assign drained = txe & tx_shift_empty & ~brk_idle_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe <= 1'b1;
         tc  <= 1'b1;
      end else begin
         if (dr_write)     txe <= 1'b0;
         else if (tx_load) txe <= 1'b1;

         if (dr_write)     tc <= 1'b0;
         else if (drained) tc <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_xfer,
   input  logic idle_hit,
   input  logic stat_read,
   input  logic dr_read,
   output logic rxf,
   output logic idle
);
   logic snap_rxf;
   logic snap_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_rxf  <= 1'b0;
         snap_idle <= 1'b0;
         rxf       <= 1'b0;
         idle      <= 1'b0;
      end else begin
         if (stat_read) begin
            snap_rxf  <= rxf;
            snap_idle <= idle;
         end else if (dr_read) begin
            snap_rxf  <= 1'b0;
            snap_idle <= 1'b0;
         end

         if (rx_xfer)                  rxf <= 1'b1;
         else if (dr_read && snap_rxf) rxf <= 1'b0;

         if (idle_hit)                  idle <= 1'b1;
         else if (dr_read && snap_idle) idle <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
   import uart_stat_pkg::*;
#(
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_load,
   input  logic tx_shift_empty,
   input  logic brk_idle_pending,
   input  logic dr_write,
   input  logic rx_xfer,
   input  logic bit_tick,
   input  logic rx_line,
   input  logic long_frame,
   input  logic stat_read,
   input  logic dr_read,
   input  logic en_txe,
   input  logic en_tc,
   input  logic en_rxf,
   input  logic en_idle,
   output logic flag_txe,
   output logic flag_tc,
   output logic flag_rxf,
   output logic flag_idle,
   output logic irq
);
   stat_t flags;
   stat_t enables;
   logic  idle_hit;

   uart_idle_detect #(
      .IDLE_SHORT(IDLE_SHORT),
      .IDLE_LONG (IDLE_LONG)
   ) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .rx_line   (rx_line),
      .long_frame(long_frame),
      .idle_hit  (idle_hit)
   );

   uart_tx_flags u_tx (
      .clk             (clk),
      .rst_n           (rst_n),
      .tx_load         (tx_load),
      .dr_write        (dr_write),
      .tx_shift_empty  (tx_shift_empty),
      .brk_idle_pending(brk_idle_pending),
      .txe             (flags.txe),
      .tc              (flags.tc)
   );

   uart_rx_flags u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_xfer  (rx_xfer),
      .idle_hit (idle_hit),
      .stat_read(stat_read),
      .dr_read  (dr_read),
      .rxf      (flags.rxf),
      .idle     (flags.idle)
   );

   assign enables = '{txe: en_txe, tc: en_tc, rxf: en_rxf, idle: en_idle};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(flags & enables);
   end

   assign flag_txe  = flags.txe;
   assign flag_tc   = flags.tc;
   assign flag_rxf  = flags.rxf;
   assign flag_idle = flags.idle;
endmodule

// File: rtl/uart_stat_flags_chk.sv
module uart_stat_flags_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_load,
   input logic tx_shift_empty,
   input logic brk_idle_pending,
   input logic dr_write,
   input logic rx_xfer,
   input logic bit_tick,
   input logic rx_line,
   input logic long_frame,
   input logic stat_read,
   input logic dr_read,
   input logic en_txe,
   input logic en_tc,
   input logic en_rxf,
   input logic en_idle,
   input logic flag_txe,
   input logic flag_tc,
   input logic flag_rxf,
   input logic flag_idle,
   input logic irq
);
   // R2
   a_r2_load_sets_txe: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !dr_write) |=> flag_txe);

   // R3 (the write clears both transmit flags)
   a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dr_write |=> (!flag_txe && !flag_tc));

   // R3
   a_r3_tc_needs_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_tc) |-> $past(flag_txe && tx_shift_empty && !brk_idle_pending));

   // R4
   a_r4_xfer_sets_rxf: assert property (@(posedge clk) disable iff (!rst_n)
      rx_xfer |=> flag_rxf);

   // R5
   a_r5_rxf_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rxf && !dr_read) |=> flag_rxf);

   // R6, R7
   a_r6_idle_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_idle) |-> $past(bit_tick && rx_line));

   // R9
   a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past((flag_txe && en_txe) || (flag_tc && en_tc) ||
                             (flag_rxf && en_rxf) || (flag_idle && en_idle))));
endmodule

bind uart_stat_flags uart_stat_flags_chk u_chk (.*);

// File: tb/test_uart_stat_flags.sv
module test_uart_stat_flags;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_load = 0, tx_shift_empty = 1, brk_idle_pending = 0, dr_write = 0;
   logic rx_xfer = 0, bit_tick = 0, rx_line = 1, long_frame = 0;
   logic stat_read = 0, dr_read = 0;
   logic en_txe = 0, en_tc = 0, en_rxf = 0, en_idle = 0;
   logic flag_txe, flag_tc, flag_rxf, flag_idle, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      string      req;
      logic [4:0] exp;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   uart_stat_flags i_uart_stat_flags (
      .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_shift_empty(tx_shift_empty),
      .brk_idle_pending(brk_idle_pending), .dr_write(dr_write), .rx_xfer(rx_xfer),
      .bit_tick(bit_tick), .rx_line(rx_line), .long_frame(long_frame),
      .stat_read(stat_read), .dr_read(dr_read), .en_txe(en_txe), .en_tc(en_tc),
      .en_rxf(en_rxf), .en_idle(en_idle), .flag_txe(flag_txe), .flag_tc(flag_tc),
      .flag_rxf(flag_rxf), .flag_idle(flag_idle), .irq(irq)
   );

   // monitor: compares {txe,tc,rxf,idle,irq} on the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [4:0] act;
         it  = sb.pop_front();
         act = {flag_txe, flag_tc, flag_rxf, flag_idle, irq};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual {txe,tc,rxf,idle,irq}=%b expected %b", it.req, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_st(string r, logic [4:0] e);
      item_t it;
      it.req = r;
      it.exp = e;
      sb.push_back(it);
   endtask

   // one strobed sample, then a gap cycle whose low line level must be ignored (R7)
   task automatic tick(logic v);
      rx_line = v; bit_tick = 1; cyc();
      bit_tick = 0; rx_line = 0; cyc();
      rx_line = 1;
   endtask

   task automatic clear_rx();
      stat_read = 1; cyc(); stat_read = 0;
      dr_read = 1; cyc(); dr_read = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; expect_st("R1 in reset", 5'b11000);
      rst_n = 1; cyc();
      expect_st("R1 after reset", 5'b11000);

      dr_write = 1; tx_shift_empty = 0; cyc(); dr_write = 0;
      expect_st("R2 write clears", 5'b00000);
      cyc(); expect_st("R3 no tc while txe low", 5'b00000);
      tx_load = 1; cyc(); tx_load = 0;
      expect_st("R2 load sets txe", 5'b10000);
      cyc(); expect_st("R3 shifter busy", 5'b10000);
      brk_idle_pending = 1; tx_shift_empty = 1; cyc(); cyc();
      expect_st("R3 break queued", 5'b10000);
      brk_idle_pending = 0; cyc();
      expect_st("R3 tc sets", 5'b11000);

      dr_write = 1; tx_load = 1; cyc(); dr_write = 0; tx_load = 0;
      expect_st("R2 write wins", 5'b00000);
      tx_load = 1; cyc(); tx_load = 0;
      expect_st("R2 reload", 5'b10000);
      cyc(); expect_st("R3 tc one edge later", 5'b11000);

      en_txe = 1; cyc(); expect_st("R9 txe request", 5'b11001);
      dr_write = 1; cyc(); dr_write = 0;
      expect_st("R9 request lags", 5'b00001);
      cyc(); expect_st("R9 request drops", 5'b00000);
      en_tc = 1; tx_load = 1; cyc(); tx_load = 0;
      expect_st("R9 registered", 5'b10000);
      cyc(); expect_st("R9 both enabled", 5'b11001);
      en_txe = 0; en_tc = 0; cyc();
      expect_st("R9 disabled", 5'b11000);
      en_tc = 1; cyc(); expect_st("R9 tc only", 5'b11001);
      en_tc = 0; cyc(); expect_st("R9 tc off", 5'b11000);

      rx_xfer = 1; cyc(); rx_xfer = 0;
      expect_st("R4 rxf sets", 5'b11100);
      dr_read = 1; cyc(); dr_read = 0;
      expect_st("R5 lone data read ignored", 5'b11100);
      en_rxf = 1; cyc(); expect_st("R9 rxf request", 5'b11101);
      stat_read = 1; cyc(); stat_read = 0;
      expect_st("R5 status read alone", 5'b11101);
      dr_read = 1; cyc(); dr_read = 0;
      expect_st("R5 sequence clears rxf", 5'b11001);
      cyc(); expect_st("R9 rxf request drops", 5'b11000);
      en_rxf = 0;

      rx_xfer = 1; cyc(); rx_xfer = 0;
      stat_read = 1; cyc(); stat_read = 0;
      dr_read = 1; rx_xfer = 1; cyc(); dr_read = 0; rx_xfer = 0;
      expect_st("R5 set wins over clear", 5'b11100);
      clear_rx(); expect_st("R5 cleared", 5'b11000);

      long_frame = 0;
      tick(0);
      repeat (9) tick(1);
      expect_st("R6 nine ones", 5'b11000);
      tick(1);
      expect_st("R6 ten ones", 5'b11010);
      en_idle = 1; cyc(); expect_st("R9 idle request", 5'b11011);
      en_idle = 0; cyc(); expect_st("R9 idle off", 5'b11010);
      clear_rx(); expect_st("R5 idle cleared", 5'b11000);
      repeat (12) tick(1);
      expect_st("R8 no second idle", 5'b11000);

      tick(0);
      repeat (4) tick(1);
      tick(0);
      repeat (9) tick(1);
      expect_st("R7 zero restarts count", 5'b11000);
      tick(1);
      expect_st("R8 rearmed by zero", 5'b11010);
      clear_rx(); expect_st("R5 idle cleared again", 5'b11000);

      long_frame = 1;
      tick(0);
      repeat (10) tick(1);
      expect_st("R6 long ten ones", 5'b11000);
      tick(1);
      expect_st("R6 long eleven ones", 5'b11010);
      clear_rx(); expect_st("R5 final clear", 5'b11000);

      @(negedge clk);
      #1;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule